// File: doc/BRIEF.md
# Instruction Stream Head Sorter

This block keeps, for every warp of a multi-threaded SIMD core, a short priority-ordered list of instruction streams. Each stream is a triple: a common program counter, a function-call depth and a thread mask with one bit per lane. The two highest-priority streams of each warp sit in two hot tables indexed by warp number. All remaining streams of that warp sit in a private last-in, first-out cold store.

On each update cycle the block receives up to three candidate streams for one warp. The caller builds them from the warp's current head, the next sequential PC and the branch or replay result. The block folds together candidates that share a PC and a call depth, drops candidates whose thread mask is empty and orders the survivors. The two best survivors are written to the hot tables. A third survivor goes onto the cold store. When only one survivor is left, the cold store refills the second hot slot. A separate lookup port reads both hot entries of any warp in the same cycle, so the instruction fetch side can follow the leading stream and the convergence logic can compare the two heads.

Top module: `isc_stream_table`

## Requirements
- R1: After reset, both hot entries of every warp read back with an all-zero mask, PC 0 and depth 0, and every cold store is empty.
- R2: Non-empty candidates with equal PC and equal call depth become one stream whose mask is the OR of their masks. No thread bit is lost or added by an update.
- R3: A candidate with an all-zero mask contributes nothing. It never occupies a hot slot ahead of a non-empty stream and is never pushed.
- R4: Survivors are ordered by larger call depth first and, on equal depth, by smaller PC. Candidates with equal PC but different depth stay separate streams.
- R5: After an update, hot entry 1 of the updated warp holds the best survivor and hot entry 2 the second best. The result is visible to a lookup of that warp in the next cycle, and other warps are unchanged.
- R6: When exactly one stream survives, hot entry 2 receives the most recently pushed stream of that warp's cold store, and that stream is removed from the store.
- R7: When exactly one stream survives and the warp's cold store is empty, hot entry 2 becomes the invalid stream (mask 0, PC 0, depth 0).
- R8: When three streams survive, the lowest-priority one is pushed onto the warp's cold store. Each store holds as many streams as there are lanes, and a push into a full store is discarded.
- R9: When no stream survives, hot entry 1 receives the popped cold head (or the invalid stream if the store is empty) and hot entry 2 becomes the invalid stream.
- R10: While the update strobe is low, no hot entry and no cold store changes, whatever the candidate inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | Apply the candidates to the warp given by upd_warp |
| upd_warp | input | WID_W | Warp being updated |
| cand_pc | input | 3 x 32 | Program counters of the three candidates |
| cand_lvl | input | 3 x 4 | Call depths of the three candidates |
| cand_mask | input | 3 x 4 | Thread masks of the three candidates |
| rd_warp | input | WID_W | Warp whose hot entries are shown |
| hot1_pc | output | 32 | PC of hot entry 1 of rd_warp |
| hot1_lvl | output | 4 | Depth of hot entry 1 of rd_warp |
| hot1_mask | output | 4 | Mask of hot entry 1 of rd_warp |
| hot2_pc | output | 32 | PC of hot entry 2 of rd_warp |
| hot2_lvl | output | 4 | Depth of hot entry 2 of rd_warp |
| hot2_mask | output | 4 | Mask of hot entry 2 of rd_warp |

## Verification
Merging and sorting act on the same candidates in the same cycle as the push to or pop from the cold store. The interesting cases are those where a fold changes the survivor count, and therefore which of the two stack operations happens. Random candidates take their PCs and depths from a set of three values each and have empty masks a quarter of the time. Three-way folds, partial folds and equal-PC/different-depth pairs therefore occur often, next to pushes and pops. Every update is judged against a bench model that folds, sorts and keeps a LIFO store per warp on its own, and the hot entries are compared in the following cycle.

// File: rtl/isc_pkg.sv
package isc_pkg;
  parameter int unsigned ISC_PC_W  = 32;
  parameter int unsigned ISC_LVL_W = 4;
  parameter int unsigned ISC_LANES = 4;
  parameter int unsigned ISC_NCAND = 3;

  typedef struct packed {
    logic [ISC_LVL_W-1:0] lvl;
    logic [ISC_PC_W-1:0]  pc;
    logic [ISC_LANES-1:0] mask;
  } isc_stream_t;

  // True when stream a must be placed ahead of stream b.
  function automatic logic isc_before(isc_stream_t a, isc_stream_t b);
    logic a_live, b_live;
    a_live = (a.mask != '0);
    b_live = (b.mask != '0);
    return a_live && (!b_live || (a.lvl > b.lvl) ||
                      ((a.lvl == b.lvl) && (a.pc < b.pc)));
  endfunction
endpackage

// File: rtl/isc_merge.sv
module isc_merge
  import isc_pkg::*;
(
  input  isc_stream_t [ISC_NCAND-1:0] cin,
  output isc_stream_t [ISC_NCAND-1:0] cout
);
  always_comb begin
    cout = cin;
    for (int i = 0; i < ISC_NCAND; i++) begin
      logic                 absorbed;
      logic [ISC_LANES-1:0] acc;
      absorbed = 1'b0;
      acc      = cin[i].mask;
      for (int j = 0; j < ISC_NCAND; j++) begin
        if ((cin[j].pc == cin[i].pc) && (cin[j].lvl == cin[i].lvl)) begin
          if (j < i && cin[j].mask != '0) absorbed = 1'b1;
          if (j > i)                      acc = acc | cin[j].mask;
        end
      end
      cout[i].mask = (absorbed || cin[i].mask == '0) ? '0 : acc;
    end
  end
endmodule

// File: rtl/isc_sort.sv
module isc_sort
  import isc_pkg::*;
(
  input  isc_stream_t [ISC_NCAND-1:0] sin,
  output isc_stream_t [ISC_NCAND-1:0] sout,
  output logic [1:0]                  nvalid
);
  isc_stream_t [ISC_NCAND-1:0] st0, st1;

  // compare-exchange network: (0,1) (1,2) (0,1); empty streams sink
  always_comb begin
    st0 = sin;
    if (isc_before(sin[1], sin[0])) begin
      st0[0] = sin[1];
      st0[1] = sin[0];
    end
    st1 = st0;
    if (isc_before(st0[2], st0[1])) begin
      st1[1] = st0[2];
      st1[2] = st0[1];
    end
    sout = st1;
    if (isc_before(st1[1], st1[0])) begin
      sout[0] = st1[1];
      sout[1] = st1[0];
    end
  end

  always_comb begin
    nvalid = 2'd0;
    for (int k = 0; k < ISC_NCAND; k++)
      if (sin[k].mask != '0) nvalid = nvalid + 2'd1;
  end
endmodule

// File: rtl/isc_cold_stack.sv
module isc_cold_stack
  import isc_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 4,
  parameter int unsigned DEPTH     = ISC_LANES,
  localparam int unsigned WID_W    = $clog2(NUM_WARPS),
  localparam int unsigned PTR_W    = $clog2(DEPTH),
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WID_W-1:0] warp,
  input  logic             push,
  input  isc_stream_t      push_data,
  input  logic             pop,
  output isc_stream_t      top_data
);
  isc_stream_t      stk_q [NUM_WARPS][DEPTH];
  logic [CNT_W-1:0] cnt_q [NUM_WARPS];
  logic [CNT_W-1:0] cnt_cur, cnt_d;
  logic             wr_en, cnt_en;

  assign cnt_cur  = cnt_q[warp];
  assign top_data = (cnt_cur == '0) ? '0 : stk_q[warp][PTR_W'(cnt_cur - 1'b1)];

  always_comb begin
    cnt_d  = cnt_cur;
    wr_en  = 1'b0;
    cnt_en = 1'b0;
    if (push) begin
      if (cnt_cur < CNT_W'(DEPTH)) begin
        wr_en  = 1'b1;
        cnt_en = 1'b1;
        cnt_d  = cnt_cur + 1'b1;
      end
    end else if (pop) begin
      if (cnt_cur != '0) begin
        cnt_en = 1'b1;
        cnt_d  = cnt_cur - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WARPS; w++) cnt_q[w] <= '0;
    end else if (cnt_en) begin
      cnt_q[warp] <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) stk_q[warp][PTR_W'(cnt_cur)] <= push_data;
  end
endmodule

// File: rtl/isc_stream_table.sv
module isc_stream_table
  import isc_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 4,
  localparam int unsigned WID_W    = $clog2(NUM_WARPS)
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                upd_valid,
  input  logic [WID_W-1:0]                    upd_warp,
  input  logic [ISC_NCAND-1:0][ISC_PC_W-1:0]  cand_pc,
  input  logic [ISC_NCAND-1:0][ISC_LVL_W-1:0] cand_lvl,
  input  logic [ISC_NCAND-1:0][ISC_LANES-1:0] cand_mask,
  input  logic [WID_W-1:0]                    rd_warp,
  output logic [ISC_PC_W-1:0]                 hot1_pc,
  output logic [ISC_LVL_W-1:0]                hot1_lvl,
  output logic [ISC_LANES-1:0]                hot1_mask,
  output logic [ISC_PC_W-1:0]                 hot2_pc,
  output logic [ISC_LVL_W-1:0]                hot2_lvl,
  output logic [ISC_LANES-1:0]                hot2_mask
);
  isc_stream_t [ISC_NCAND-1:0] cand_s, merged_s, srt_s;
  logic [1:0]  nvalid_s;
  isc_stream_t hot1_q [NUM_WARPS];
  isc_stream_t hot2_q [NUM_WARPS];
  isc_stream_t h1_d, h2_d, cold_top;
  logic        push_s, pop_s;

  for (genvar i = 0; i < ISC_NCAND; i++) begin : g_cand
    assign cand_s[i].pc   = cand_pc[i];
    assign cand_s[i].lvl  = cand_lvl[i];
    assign cand_s[i].mask = cand_mask[i];
  end

  isc_merge i_merge (.cin(cand_s), .cout(merged_s));
  isc_sort  i_sort  (.sin(merged_s), .sout(srt_s), .nvalid(nvalid_s));

  isc_cold_stack #(.NUM_WARPS(NUM_WARPS), .DEPTH(ISC_LANES)) i_cold (
    .clk(clk), .rst_n(rst_n), .warp(upd_warp),
    .push(push_s), .push_data(srt_s[2]), .pop(pop_s), .top_data(cold_top));

  // next-state for the selected warp
  always_comb begin
    h1_d   = hot1_q[upd_warp];
    h2_d   = hot2_q[upd_warp];
    push_s = 1'b0;
    pop_s  = 1'b0;
    if (upd_valid) begin
      case (nvalid_s)
        2'd3: begin h1_d = srt_s[0]; h2_d = srt_s[1]; push_s = 1'b1; end
        2'd2: begin h1_d = srt_s[0]; h2_d = srt_s[1]; end
        2'd1: begin h1_d = srt_s[0]; h2_d = cold_top; pop_s = 1'b1; end
        default: begin h1_d = cold_top; h2_d = '0; pop_s = 1'b1; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WARPS; w++) begin
        hot1_q[w] <= '0;
        hot2_q[w] <= '0;
      end
    end else if (upd_valid) begin
      hot1_q[upd_warp] <= h1_d;
      hot2_q[upd_warp] <= h2_d;
    end
  end

  assign hot1_pc   = hot1_q[rd_warp].pc;
  assign hot1_lvl  = hot1_q[rd_warp].lvl;
  assign hot1_mask = hot1_q[rd_warp].mask;
  assign hot2_pc   = hot2_q[rd_warp].pc;
  assign hot2_lvl  = hot2_q[rd_warp].lvl;
  assign hot2_mask = hot2_q[rd_warp].mask;
endmodule

// File: rtl/isc_stream_table_chk.sv
module isc_stream_table_chk
  import isc_pkg::*;
#(
  parameter int unsigned NUM_WARPS = 4,
  localparam int unsigned WID_W    = $clog2(NUM_WARPS)
) (
  input logic                                clk,
  input logic                                rst_n,
  input logic                                upd_valid,
  input logic [WID_W-1:0]                    upd_warp,
  input logic [WID_W-1:0]                    rd_warp,
  input logic [ISC_NCAND-1:0][ISC_LANES-1:0] cand_mask,
  input isc_stream_t [ISC_NCAND-1:0]         srt_s,
  input logic [1:0]                          nvalid_s,
  input logic [ISC_LANES-1:0]                hot1_mask,
  input logic [ISC_LANES-1:0]                hot2_mask
);
  // R4
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && nvalid_s >= 2'd2) |-> isc_before(srt_s[0], srt_s[1]));

  // R3
  packing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ((srt_s[1].mask == '0 || srt_s[0].mask != '0) &&
                   (srt_s[2].mask == '0 || srt_s[1].mask != '0)));

  // R2
  threads_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> ((srt_s[0].mask | srt_s[1].mask | srt_s[2].mask) ==
                   (cand_mask[0] | cand_mask[1] | cand_mask[2])));

  // R5
  visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && nvalid_s != 2'd0 && rd_warp == upd_warp)
      |=> (!$stable(rd_warp) || hot1_mask != '0));

  // R9
  second_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && nvalid_s == 2'd0 && rd_warp == upd_warp)
      |=> (!$stable(rd_warp) || hot2_mask == '0));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid) |=> (!$stable(rd_warp) ||
                      ($stable(hot1_mask) && $stable(hot2_mask))));
endmodule

bind isc_stream_table isc_stream_table_chk #(.NUM_WARPS(NUM_WARPS)) i_isc_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_warp(upd_warp),
  .rd_warp(rd_warp), .cand_mask(cand_mask), .srt_s(srt_s),
  .nvalid_s(nvalid_s), .hot1_mask(hot1_mask), .hot2_mask(hot2_mask));

// File: tb/test_isc_stream_table.sv
module test_isc_stream_table;
  import isc_pkg::*;
  localparam int unsigned NW    = 4;
  localparam int unsigned WID_W = $clog2(NW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic upd_valid = 1'b0;
  logic [WID_W-1:0] upd_warp = '0, rd_warp = '0;
  logic [ISC_NCAND-1:0][ISC_PC_W-1:0]  cand_pc = '0;
  logic [ISC_NCAND-1:0][ISC_LVL_W-1:0] cand_lvl = '0;
  logic [ISC_NCAND-1:0][ISC_LANES-1:0] cand_mask = '0;
  logic [ISC_PC_W-1:0]  hot1_pc, hot2_pc;
  logic [ISC_LVL_W-1:0] hot1_lvl, hot2_lvl;
  logic [ISC_LANES-1:0] hot1_mask, hot2_mask;

  always #2.5 clk = ~clk;

  isc_stream_table #(.NUM_WARPS(NW)) i_isc_stream_table (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_warp(upd_warp),
    .cand_pc(cand_pc), .cand_lvl(cand_lvl), .cand_mask(cand_mask),
    .rd_warp(rd_warp), .hot1_pc(hot1_pc), .hot1_lvl(hot1_lvl),
    .hot1_mask(hot1_mask), .hot2_pc(hot2_pc), .hot2_lvl(hot2_lvl),
    .hot2_mask(hot2_mask));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model
  isc_stream_t m_h1 [NW];
  isc_stream_t m_h2 [NW];
  isc_stream_t m_stk [NW][ISC_LANES];
  int          m_cnt [NW];

  function automatic isc_stream_t mk(int unsigned pc, int unsigned lvl, int unsigned mask);
    isc_stream_t s;
    s.pc = ISC_PC_W'(pc); s.lvl = ISC_LVL_W'(lvl); s.mask = ISC_LANES'(mask);
    return s;
  endfunction

  task automatic check(string tag, isc_stream_t act, isc_stream_t exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual pc=%h lvl=%0d mask=%b expected pc=%h lvl=%0d mask=%b",
               tag, act.pc, act.lvl, act.mask, exp.pc, exp.lvl, exp.mask);
    end
  endtask

  task automatic check_warp(string tag, int w);
    rd_warp = WID_W'(w);
    #1;
    check({tag, " hot1"}, mk(hot1_pc, hot1_lvl, hot1_mask), m_h1[w]);
    check({tag, " hot2"}, mk(hot2_pc, hot2_lvl, hot2_mask), m_h2[w]);
  endtask

  function automatic isc_stream_t m_pop(int w);
    isc_stream_t s;
    if (m_cnt[w] == 0) return '0;
    m_cnt[w]--;
    s = m_stk[w][m_cnt[w]];
    return s;
  endfunction

  // Fold equal keys, drop empty masks, order by depth desc then PC asc.
  task automatic model_update(int w, isc_stream_t c0, isc_stream_t c1, isc_stream_t c2);
    isc_stream_t in [3];
    isc_stream_t lst [3];
    int n = 0;
    in[0] = c0; in[1] = c1; in[2] = c2;
    for (int i = 0; i < 3; i++) begin
      int hit = -1;
      if (in[i].mask == '0) continue;
      for (int k = 0; k < n; k++)
        if (lst[k].pc == in[i].pc && lst[k].lvl == in[i].lvl) hit = k;
      if (hit >= 0) lst[hit].mask |= in[i].mask;
      else begin lst[n] = in[i]; n++; end
    end
    for (int a = 0; a < n; a++)
      for (int b = a + 1; b < n; b++)
        if (lst[b].lvl > lst[a].lvl || (lst[b].lvl == lst[a].lvl && lst[b].pc < lst[a].pc)) begin
          isc_stream_t t = lst[a]; lst[a] = lst[b]; lst[b] = t;
        end
    case (n)
      3: begin
        m_h1[w] = lst[0]; m_h2[w] = lst[1];
        if (m_cnt[w] < ISC_LANES) begin m_stk[w][m_cnt[w]] = lst[2]; m_cnt[w]++; end
      end
      2: begin m_h1[w] = lst[0]; m_h2[w] = lst[1]; end
      1: begin m_h1[w] = lst[0]; m_h2[w] = m_pop(w); end
      default: begin m_h1[w] = m_pop(w); m_h2[w] = '0; end
    endcase
  endtask

  task automatic do_upd(string tag, int w, isc_stream_t c0, isc_stream_t c1, isc_stream_t c2);
    @(negedge clk);
    upd_valid = 1'b1; upd_warp = WID_W'(w); rd_warp = WID_W'(w);
    cand_pc[0] = c0.pc; cand_lvl[0] = c0.lvl; cand_mask[0] = c0.mask;
    cand_pc[1] = c1.pc; cand_lvl[1] = c1.lvl; cand_mask[1] = c1.mask;
    cand_pc[2] = c2.pc; cand_lvl[2] = c2.lvl; cand_mask[2] = c2.mask;
    model_update(w, c0, c1, c2);
    @(negedge clk);
    upd_valid = 1'b0;
    check_warp(tag, w);
  endtask

  function automatic isc_stream_t rnd_stream();
    int unsigned m = $urandom % 16;
    if (($urandom % 4) == 0) m = 0;
    return mk(32'h100 + 4 * ($urandom % 3), $urandom % 3, m);
  endfunction

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int w = 0; w < NW; w++) begin m_h1[w] = '0; m_h2[w] = '0; m_cnt[w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state of every warp
    for (int w = 0; w < NW; w++) check_warp("R1 reset", w);

    // R2: equal key folds into one stream (mask 0101)
    do_upd("R2 fold", 0, mk(32'h200, 1, 4'b0001), mk(32'h200, 1, 4'b0100), mk(32'h0, 0, 0));
    check("R2 fold literal", mk(hot1_pc, hot1_lvl, hot1_mask), mk(32'h200, 1, 4'b0101));
    // R3: empty candidate ahead of a live one is dropped
    do_upd("R3 empty", 0, mk(32'h10, 7, 0), mk(32'h500, 0, 4'b1000), mk(32'h600, 0, 0));
    check("R3 literal", mk(hot1_pc, hot1_lvl, hot1_mask), mk(32'h500, 0, 4'b1000));
    // R4: equal PC, different depth kept separate, deeper first
    do_upd("R4 depth", 0, mk(32'h300, 0, 4'b0001), mk(32'h300, 2, 4'b0010), mk(32'h0, 0, 0));
    check("R4 depth literal", mk(hot2_pc, hot2_lvl, hot2_mask), mk(32'h300, 0, 4'b0001));
    // R4: equal depth, smaller PC first
    do_upd("R4 pc", 0, mk(32'h40, 1, 4'b0001), mk(32'h20, 1, 4'b0010), mk(32'h0, 0, 0));
    check("R4 pc literal", mk(hot1_pc, hot1_lvl, hot1_mask), mk(32'h20, 1, 4'b0010));

    // R8 push then R6 pop on warp 1
    do_upd("R8 push", 1, mk(32'h10, 0, 4'b0001), mk(32'h20, 0, 4'b0010), mk(32'h30, 0, 4'b0100));
    do_upd("R6 pop", 1, mk(32'h40, 0, 4'b1000), mk(32'h0, 0, 0), mk(32'h0, 0, 0));
    check("R6 literal", mk(hot2_pc, hot2_lvl, hot2_mask), mk(32'h30, 0, 4'b0100));
    // R7 pop of an empty store
    do_upd("R7 empty pop", 1, mk(32'h40, 0, 4'b1000), mk(32'h0, 0, 0), mk(32'h0, 0, 0));
    check("R7 literal", mk(hot2_pc, hot2_lvl, hot2_mask), '0);
    // R5: warp 0 untouched by warp 1 traffic
    check_warp("R5 isolation", 0);

    // R9: no survivors pulls the cold head into hot entry 1
    do_upd("R9 setup", 2, mk(32'h10, 1, 4'b0001), mk(32'h14, 1, 4'b0010), mk(32'h18, 1, 4'b0100));
    do_upd("R9 refill", 2, mk(32'h0, 0, 0), mk(32'h0, 0, 0), mk(32'h0, 0, 0));
    check("R9 literal", mk(hot1_pc, hot1_lvl, hot1_mask), mk(32'h18, 1, 4'b0100));

    // R8: full store discards pushes, drain shows only ISC_LANES entries
    for (int k = 0; k < ISC_LANES + 2; k++)
      do_upd("R8 fill", 3, mk(32'h100, 0, 1), mk(32'h104, 0, 2), mk(32'h200 + 4 * k, 0, 4));
    for (int k = 0; k < ISC_LANES + 1; k++)
      do_upd("R8 drain", 3, mk(32'h0, 0, 0), mk(32'h0, 0, 0), mk(32'h0, 0, 0));

    // R10: strobe low, garbage candidates
    @(negedge clk);
    upd_warp = 2'd0; rd_warp = 2'd0;
    cand_mask = '1; cand_pc = '1; cand_lvl = '1;
    @(negedge clk);
    check_warp("R10 hold", 0);

    // random mix, R2 R4 R5 R6 R8 R9 against the model
    for (int it = 0; it < 600; it++)
      do_upd("R5 random", $urandom % NW, rnd_stream(), rnd_stream(), rnd_stream());
    for (int w = 0; w < NW; w++) check_warp("R5 final", w);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule